// File: doc/BRIEF.md
# Shared Interrupt Router

This block collects a parameterised number of shared interrupt lines and delivers them to several processor targets. The number of lines is `GROUPS * 8`. Each line has its own settings. It can be sensed as a level of either sense, or as an edge of either direction, or on both edges. Every line keeps a pending indication and an enable bit. Each line can be steered to one output pin of one target.

Software works through a word-addressed register port. Writes are single-cycle and reads are combinational.

Enables are changed by writing a line index to one of two command addresses, one that enables and one that disables. A third command address drops an edge line's latched pending state or forces it on. The forcing path is what lets one processor interrupt another.

Each line's sensing is built around a two-state latch, `LATCH_IDLE` and `LATCH_HELD`, with these transitions:
- `LATCH_IDLE` goes to `LATCH_HELD` on a qualifying edge or a force command.
- `LATCH_HELD` goes to `LATCH_IDLE` only on a clear command that does not coincide with a qualifying edge.

For a level line the latch is bypassed and pending follows the synchronised input.

Top module: `irq_route_ctrl`

## Requirements
- R1: The word at address 0x000 returns `GROUPS-1` in bits [7:0], so software computes the line count as (field + 1) * 8.
- R2: After reset every line is active-high, level-sensed, single-edge and disabled. Polarity words read all ones for existing lines, trigger and dual words read zero, every pin-map and target word reads zero, and all outputs are low.
- R3: Writing an index to 0x001 enables that line and writing an index to 0x002 disables it. The index is taken from bits [7:0]. An index at or above the line count changes nothing. Enable bits read back packed at 0x018+w. Disabling a line does not alter its pending bit.
- R4: A level line (trigger bit 0 in the word at 0x028+w) is pending when its input, after a two-flop synchroniser, equals its polarity bit (word 0x020+w, 1 = active high, 0 = active low). Pending bits read packed at 0x010+w, with line s at word s/32, bit s%32.
- R5: An edge line (trigger bit 1) latches pending on a rising edge when its polarity bit is 1, or on a falling edge when it is 0. The latch holds until a clear command. The latch is set on the third clock edge after the raw input changes.
- R6: With the dual bit set (word 0x030+w), an edge line latches on both edges whatever its polarity bit.
- R7: Writing 0x003 with bit 31 = 1 forces the latch of line wdata[7:0] on. Writing 0x003 with bit 31 = 0 clears that latch.
- R8: A clear command in the same cycle as a qualifying edge on that line leaves the latch set.
- R9: Line s is routed by two registers. The pin-map at 0x100+s holds bit 31 = map enable and the low bits = pin number. The target register at 0x200+s holds a one-hot target select. Output `irq_out[t*PINS+p]` is the OR, over lines whose map enable is set with pin p and target bit t, of pending AND enabled.
- R10: A line whose map enable is clear drives no output, even while pending and enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_raw | input | GROUPS*8 | Raw interrupt lines |
| irq_out | output | TARGETS*PINS | Per-target pin outputs |

## Verification
The bench targets a clear command issued in exactly the cycle a synchronised edge is detected. A design that lets the clear win would drop that interrupt and read the pending bit as zero. Falling-edge and dual-edge lines are driven in both directions. A design that ignored the polarity bit, or consulted it in dual mode, would latch on the wrong transition. Out-of-range enable indices and cleared map-enable flags are checked at the outputs and mask words. Getting either wrong would enable a real line through index aliasing, or would raise a pin that software had unmapped.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    // Word addresses of the register port
    localparam int A_CFG  = 'h000;
    localparam int A_MSET = 'h001;
    localparam int A_MCLR = 'h002;
    localparam int A_CMD  = 'h003;
    localparam int A_PEND = 'h010;
    localparam int A_MASK = 'h018;
    localparam int A_POL  = 'h020;
    localparam int A_TRIG = 'h028;
    localparam int A_DUAL = 'h030;
    localparam int A_PMAP = 'h100;
    localparam int A_TGT  = 'h200;

    // Command word: bit 31 selects force (1) or clear (0)
    localparam int CMD_FORCE_BIT = 31;

    typedef enum logic {
        LATCH_IDLE = 1'b0,
        LATCH_HELD = 1'b1
    } latch_state_e;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_in;
            stage2_q <= stage1_q;
        end
    end

    assign d_out = stage2_q;
endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell
    import irq_route_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic pol,
    input  logic trig,
    input  logic dual,
    input  logic cmd_set,
    input  logic cmd_clr,
    output logic pend,
    output logic held
);
    latch_state_e st_q, st_d;
    logic prev_q;
    logic rise, fall, hit;

    assign rise = sync_in & ~prev_q;
    assign fall = ~sync_in & prev_q;
    assign hit  = trig & (dual ? (rise | fall) : (pol ? rise : fall));

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LATCH_IDLE: if (hit || cmd_set) st_d = LATCH_HELD;
            LATCH_HELD: if (cmd_clr && !hit) st_d = LATCH_IDLE;
            default:    st_d = LATCH_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= LATCH_IDLE;
            prev_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            prev_q <= sync_in;
        end
    end

    // Outputs
    always_comb begin
        held = (st_q == LATCH_HELD);
        pend = trig ? held : (sync_in ~^ pol);
    end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_route_pkg::*;
#(
    parameter int NSRC = 16,
    parameter int NT   = 2,
    parameter int PW   = 2,
    parameter int AW   = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [AW-1:0]            addr,
    input  logic [31:0]              wdata,
    output logic [NSRC-1:0]          mask_q,
    output logic [NSRC-1:0]          pol_q,
    output logic [NSRC-1:0]          trig_q,
    output logic [NSRC-1:0]          dual_q,
    output logic [NSRC-1:0]          map_en_q,
    output logic [NSRC-1:0][PW-1:0]  pin_q,
    output logic [NSRC-1:0][NT-1:0]  tgt_q,
    output logic [NSRC-1:0]          cmd_set,
    output logic [NSRC-1:0]          cmd_clr
);
    logic [7:0] idx;
    logic       unused_wdata;

    assign idx          = wdata[7:0];
    assign unused_wdata = ^wdata;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        localparam int WI = s / 32;
        localparam int BI = s % 32;

        logic          en_r, pol_r, trig_r, dual_r, men_r;
        logic [PW-1:0] pin_r;
        logic [NT-1:0] tgt_r;
        logic          idx_hit;

        assign idx_hit = (idx == 8'(s));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_r   <= 1'b0;
                pol_r  <= 1'b1;
                trig_r <= 1'b0;
                dual_r <= 1'b0;
                men_r  <= 1'b0;
                pin_r  <= '0;
                tgt_r  <= '0;
            end else if (we) begin
                if (addr == AW'(A_MSET) && idx_hit) en_r <= 1'b1;
                if (addr == AW'(A_MCLR) && idx_hit) en_r <= 1'b0;
                if (addr == AW'(A_POL + WI))  pol_r  <= wdata[BI];
                if (addr == AW'(A_TRIG + WI)) trig_r <= wdata[BI];
                if (addr == AW'(A_DUAL + WI)) dual_r <= wdata[BI];
                if (addr == AW'(A_PMAP + s)) begin
                    men_r <= wdata[31];
                    pin_r <= wdata[PW-1:0];
                end
                if (addr == AW'(A_TGT + s)) tgt_r <= wdata[NT-1:0];
            end
        end

        assign mask_q[s]   = en_r;
        assign pol_q[s]    = pol_r;
        assign trig_q[s]   = trig_r;
        assign dual_q[s]   = dual_r;
        assign map_en_q[s] = men_r;
        assign pin_q[s]    = pin_r;
        assign tgt_q[s]    = tgt_r;
        assign cmd_set[s]  = we && (addr == AW'(A_CMD)) && idx_hit &&  wdata[CMD_FORCE_BIT];
        assign cmd_clr[s]  = we && (addr == AW'(A_CMD)) && idx_hit && !wdata[CMD_FORCE_BIT];
    end
endmodule

// File: rtl/irq_pin_merge.sv
module irq_pin_merge #(
    parameter int NSRC = 16,
    parameter int NT   = 2,
    parameter int NP   = 4,
    parameter int PW   = 2
) (
    input  logic [NSRC-1:0]          live,
    input  logic [NSRC-1:0]          map_en,
    input  logic [NSRC-1:0][PW-1:0]  pin,
    input  logic [NSRC-1:0][NT-1:0]  tgt,
    output logic [NT*NP-1:0]         irq_out
);
    for (genvar t = 0; t < NT; t++) begin : g_tgt
        for (genvar p = 0; p < NP; p++) begin : g_pin
            logic acc;
            always_comb begin
                acc = 1'b0;
                for (int s = 0; s < NSRC; s++) begin
                    acc = acc | (live[s] & map_en[s] & tgt[s][t] & (pin[s] == PW'(p)));
                end
            end
            assign irq_out[t*NP + p] = acc;
        end
    end
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int GROUPS  = 2,
    parameter int TARGETS = 2,
    parameter int PINS    = 4,
    parameter int ADDR_W  = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_we,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    input  logic [GROUPS*8-1:0]       irq_raw,
    output logic [TARGETS*PINS-1:0]   irq_out
);
    localparam int NSRC   = GROUPS * 8;
    localparam int PW     = (PINS > 1) ? $clog2(PINS) : 1;
    localparam int NWORDS = (NSRC + 31) / 32;

    logic [NSRC-1:0]             sync_v;
    logic [NSRC-1:0]             mask_q, pol_q, trig_q, dual_q, map_en_q;
    logic [NSRC-1:0][PW-1:0]     pin_q;
    logic [NSRC-1:0][TARGETS-1:0] tgt_q;
    logic [NSRC-1:0]             cmd_set, cmd_clr;
    logic [NSRC-1:0]             pend_vec, held_vec;

    irq_sync #(.W(NSRC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (irq_raw),
        .d_out (sync_v)
    );

    irq_cfg_regs #(.NSRC(NSRC), .NT(TARGETS), .PW(PW), .AW(ADDR_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (bus_we),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .mask_q   (mask_q),
        .pol_q    (pol_q),
        .trig_q   (trig_q),
        .dual_q   (dual_q),
        .map_en_q (map_en_q),
        .pin_q    (pin_q),
        .tgt_q    (tgt_q),
        .cmd_set  (cmd_set),
        .cmd_clr  (cmd_clr)
    );

    for (genvar s = 0; s < NSRC; s++) begin : g_cell
        irq_src_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .sync_in (sync_v[s]),
            .pol     (pol_q[s]),
            .trig    (trig_q[s]),
            .dual    (dual_q[s]),
            .cmd_set (cmd_set[s]),
            .cmd_clr (cmd_clr[s]),
            .pend    (pend_vec[s]),
            .held    (held_vec[s])
        );
    end

    irq_pin_merge #(.NSRC(NSRC), .NT(TARGETS), .NP(PINS), .PW(PW)) u_merge (
        .live    (pend_vec & mask_q),
        .map_en  (map_en_q),
        .pin     (pin_q),
        .tgt     (tgt_q),
        .irq_out (irq_out)
    );

    // Packed views for word reads
    logic [NWORDS*32-1:0] pend_pad, mask_pad, pol_pad, trig_pad, dual_pad;
    assign pend_pad = (NWORDS*32)'(pend_vec);
    assign mask_pad = (NWORDS*32)'(mask_q);
    assign pol_pad  = (NWORDS*32)'(pol_q);
    assign trig_pad = (NWORDS*32)'(trig_q);
    assign dual_pad = (NWORDS*32)'(dual_q);

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_CFG)) bus_rdata[7:0] = 8'(GROUPS - 1);
        for (int w = 0; w < NWORDS; w++) begin
            if (bus_addr == ADDR_W'(A_PEND + w)) bus_rdata = pend_pad[w*32 +: 32];
            if (bus_addr == ADDR_W'(A_MASK + w)) bus_rdata = mask_pad[w*32 +: 32];
            if (bus_addr == ADDR_W'(A_POL  + w)) bus_rdata = pol_pad[w*32 +: 32];
            if (bus_addr == ADDR_W'(A_TRIG + w)) bus_rdata = trig_pad[w*32 +: 32];
            if (bus_addr == ADDR_W'(A_DUAL + w)) bus_rdata = dual_pad[w*32 +: 32];
        end
        for (int s = 0; s < NSRC; s++) begin
            if (bus_addr == ADDR_W'(A_PMAP + s))
                bus_rdata = {map_en_q[s], {(31-PW){1'b0}}, pin_q[s]};
            if (bus_addr == ADDR_W'(A_TGT + s))
                bus_rdata = 32'(tgt_q[s]);
        end
    end
endmodule

// File: rtl/irq_route_ctrl_chk.sv
module irq_route_ctrl_chk
    import irq_route_pkg::*;
#(
    parameter int NSRC = 16,
    parameter int AW   = 10,
    parameter int NO   = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_we,
    input logic [AW-1:0]   bus_addr,
    input logic [31:0]     bus_wdata,
    input logic [NSRC-1:0] mask_q,
    input logic [NSRC-1:0] held,
    input logic [NO-1:0]   irq_out
);
    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic unused_bits;
    assign unused_bits = ^bus_wdata[30:8];

    logic idx_in_range;
    assign idx_in_range = int'(bus_wdata[7:0]) < NSRC;

    // R3: enabling by index takes effect on the next cycle
    p_mask_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AW'(A_MSET) && idx_in_range)
        |=> mask_q[$past(bus_wdata[IW-1:0])]);

    // R3: disabling by index takes effect on the next cycle
    p_mask_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AW'(A_MCLR) && idx_in_range)
        |=> !mask_q[$past(bus_wdata[IW-1:0])]);

    // R7: force command sets the latch
    p_cmd_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AW'(A_CMD) && bus_wdata[CMD_FORCE_BIT] && idx_in_range)
        |=> held[$past(bus_wdata[IW-1:0])]);

    // R9: with nothing enabled, no output may be raised
    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> (irq_out == '0));

    // R5: a held latch only drops after a clear command to that line
    for (genvar s = 0; s < NSRC; s++) begin : g_hold
        p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (held[s] && !(bus_we && bus_addr == AW'(A_CMD)
                          && !bus_wdata[CMD_FORCE_BIT] && bus_wdata[7:0] == 8'(s)))
            |=> held[s]);
    end
endmodule

bind irq_route_ctrl irq_route_ctrl_chk #(.NSRC(NSRC), .AW(ADDR_W), .NO(TARGETS*PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .mask_q    (mask_q),
    .held      (held_vec),
    .irq_out   (irq_out)
);

// File: tb/sim_irq_route_ctrl.sv
`timescale 1ns/1ps
module sim_irq_route_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] irq_raw = '0;
    logic [7:0]  irq_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_route_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_raw   (irq_raw),
        .irq_out   (irq_out)
    );

    typedef struct {
        bit          is_pin;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    item_t cur;
    logic [31:0] act;

    // Monitor: pops expectations and compares against the design
    always @(negedge clk) begin
        #2;
        if (q.size() != 0) begin
            cur = q.pop_front();
            act = cur.is_pin ? 32'(irq_out) : bus_rdata;
            n_cmp++;
            if (act !== cur.exp) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", cur.tag, act, cur.exp);
            end
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 10'(a); bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic chk_reg(input int a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_addr = 10'(a);
        it.is_pin = 1'b0; it.exp = e; it.tag = tag;
        q.push_back(it);
        @(posedge clk);
    endtask

    task automatic chk_out(input logic [7:0] e, input string tag);
        item_t it;
        @(negedge clk);
        it.is_pin = 1'b1; it.exp = 32'(e); it.tag = tag;
        q.push_back(it);
        @(posedge clk);
    endtask

    task automatic drive(input int s, input logic v);
        @(negedge clk);
        irq_raw[s] = v;
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        tick(3);
        @(negedge clk) rst_n = 1'b1;

        // Reset state and configuration word
        chk_reg('h000, 32'h1,        "R1 count field");
        chk_reg('h010, 32'h0,        "R2 pending after reset");
        chk_reg('h018, 32'h0,        "R2 masks after reset");
        chk_reg('h020, 32'h0000FFFF, "R2 polarity after reset");
        chk_reg('h028, 32'h0,        "R2 trigger after reset");
        chk_reg('h103, 32'h0,        "R2 pin-map after reset");
        chk_out(8'h00,               "R2 outputs after reset");

        // Route line 3 to target 1 pin 2, enable, try an out-of-range index
        wr('h103, 32'h8000_0002);
        wr('h203, 32'h2);
        wr('h001, 32'd3);
        wr('h001, 32'd20);
        chk_reg('h018, 32'h8,         "R3 mask set and ignored index");
        chk_reg('h103, 32'h8000_0002, "R9 pin-map readback");

        // Level high
        drive(3, 1'b1); tick(3);
        chk_reg('h010, 32'h8, "R4 level high pending");
        chk_out(8'h40,        "R9 target1 pin2 output");
        wr('h002, 32'd3);
        chk_out(8'h00,        "R3 disabled line silent");
        chk_reg('h010, 32'h8, "R3 pending kept while disabled");
        wr('h001, 32'd3);
        drive(3, 1'b0); tick(3);
        chk_reg('h010, 32'h0, "R4 level released");
        chk_out(8'h00,        "R4 output released");

        // Active-low level
        wr('h020, 32'h0000FFF7); tick(1);
        chk_reg('h010, 32'h8, "R4 active low pending");
        chk_out(8'h40,        "R4 active low output");
        wr('h020, 32'h0000FFFF); tick(1);
        chk_reg('h010, 32'h0, "R4 polarity restored");

        // Rising edge on line 5 routed to target 0 pin 0
        wr('h028, 32'h20);
        wr('h105, 32'h8000_0000);
        wr('h205, 32'h1);
        wr('h001, 32'd5);
        drive(5, 1'b1); tick(3);
        chk_reg('h010, 32'h20, "R5 rising edge latched");
        chk_out(8'h01,         "R9 target0 pin0 output");
        drive(5, 1'b0); tick(3);
        chk_reg('h010, 32'h20, "R5 latch held after input drops");
        wr('h003, 32'd5);
        chk_reg('h010, 32'h0,  "R7 clear command");
        chk_out(8'h00,         "R7 output after clear");

        // Falling edge
        wr('h020, 32'h0000FFDF);
        drive(5, 1'b1); tick(3);
        chk_reg('h010, 32'h0,  "R5 rising ignored in falling mode");
        drive(5, 1'b0); tick(3);
        chk_reg('h010, 32'h20, "R5 falling edge latched");
        wr('h003, 32'd5);
        chk_reg('h010, 32'h0,  "R7 clear after falling");

        // Dual edge, polarity bit left at falling
        wr('h030, 32'h20);
        drive(5, 1'b1); tick(3);
        chk_reg('h010, 32'h20, "R6 dual rising");
        wr('h003, 32'd5);
        chk_reg('h010, 32'h0,  "R7 clear in dual");
        drive(5, 1'b0); tick(3);
        chk_reg('h010, 32'h20, "R6 dual falling");
        wr('h003, 32'd5);

        // Software force on line 9 routed to target 0 pin 3
        wr('h028, 32'h220);
        wr('h109, 32'h8000_0003);
        wr('h209, 32'h1);
        wr('h001, 32'd9);
        wr('h003, 32'h8000_0009);
        chk_reg('h010, 32'h200, "R7 force command");
        chk_out(8'h08,          "R9 forced line output");

        // Map enable cleared
        wr('h109, 32'h0000_0003);
        chk_out(8'h00,          "R10 unmapped line silent");
        chk_reg('h010, 32'h200, "R10 pending unaffected by map");

        // Clear coinciding with a detected edge on line 5
        drive(5, 1'b1);
        @(posedge clk); @(posedge clk);
        wr('h003, 32'd5);
        chk_reg('h010, 32'h220, "R8 edge wins over clear");
        wr('h003, 32'd5);
        chk_reg('h010, 32'h200, "R7 later clear");

        tick(2);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule